// File: doc/BRIEF.md
# Multicycle Shared-Memory Processor Core

This block is a small 32-bit processor core that runs each instruction over several clock cycles and reuses the same hardware from one step to the next. There is one memory port for both instruction fetches and data accesses. A single select picks whether the address comes from the program counter or from the computed-address register. There is also one ALU, and it does every addition the core needs: the program-counter increment, the branch target, the effective address of loads and stores, and register arithmetic. Each instruction starts with a fetch step in which the ALU writes PC+4 back into the program counter.

The datapath holds the program counter, an instruction register, two operand registers, an ALU result register, a branch-target buffer and a register file with a hardwired zero register. The decode step always computes the branch target from the already-incremented PC and stores it in the target buffer. A later step compares the two source registers. If they are equal, the buffered target is loaded into the PC. Otherwise the PC keeps PC+4. The memory is synchronous: read data appears in the cycle after the address is presented.

The core is meant to sit in front of a single-port synchronous RAM that returns registered read data. Four operations are supported: word load, word store, register add/subtract and branch-if-equal.

Top module: `mc_core`

## Requirements
- R1: While reset is held, the core presents a read at address RESET_PC with the write enable low. The first instruction after reset is fetched from RESET_PC.
- R2: Every instruction starts with one fetch cycle: read enable high, write enable low, address equal to the current PC. The next instruction is fetched at PC+4 unless a branch was taken.
- R3: Instruction lengths are fixed: load 6 cycles, store 5, add/sub 5, branch 4, any other encoding 3. Apart from the fetch, memory is touched only by the load read and the store write.
- R4: Encoding: the opcode is bits 31:26, rs is 25:21, rt is 20:16, rd is 15:11, the 16-bit immediate is 15:0 and the function code is 5:0. Opcode 0x23 is load, 0x2B is store and 0x04 is branch-if-equal. Opcode 0x00 with function 0x20 is add and with function 0x22 is subtract.
- R5: Load and store use the address rs + sign-extended immediate. A load reads in its 5th cycle and writes the read word into rt. A store writes the value of rt in its 5th cycle.
- R6: Add and subtract write rs+rt or rs-rt, modulo 2^32, into rd.
- R7: Branch-if-equal moves to PC+4 + (sign-extended immediate << 2) when rs equals rt, and to PC+4 otherwise. Negative offsets are included.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: An unrecognised encoding changes no register and no memory word.
- R10: Read enable and write enable are never high in the same cycle, and a store is always the last cycle of its instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address to the shared memory |
| mem_re | output | 1 | Read request; data returns on the following cycle |
| mem_we | output | 1 | Write request |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Registered read data from memory |

## Verification
The program first loads two unequal constants. It then adds and subtracts them: one result is positive and one wraps negative. A branch is not taken because its operands differ, and a later branch is taken because both operands name the same register; the taken branch jumps over a store, and that skipped store shows whether the Target buffer was used. A store through a base register with a negative offset checks that the effective address is sign extended. An add into register 0 followed by a store of register 0 shows that register 0 really stays zero. An illegal opcode followed by more work checks the three-cycle no-op path. The program ends in a branch to itself, which tests the negative branch offset on every pass.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [3:0] {
    S_IF, S_IW, S_ID, S_EA, S_MR, S_WB, S_MS, S_EX, S_RW, S_BR
  } state_t;

  // R4 opcode and function encodings
  localparam logic [5:0] OP_RT  = 6'h00;
  localparam logic [5:0] OP_LW  = 6'h23;
  localparam logic [5:0] OP_SW  = 6'h2B;
  localparam logic [5:0] OP_BEQ = 6'h04;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;

  typedef enum logic [1:0] {
    BSEL_REG, BSEL_FOUR, BSEL_IMM, BSEL_BOFF
  } bsel_t;

  typedef struct packed {
    logic  iord;
    logic  pc_write;
    logic  pc_write_cond;
    logic  pc_src;
    logic  target_write;
    logic  a_sel;
    bsel_t b_sel;
    logic  alu_sub;
    logic  ir_write;
    logic  ab_write;
    logic  aluout_write;
    logic  mem_re;
    logic  mem_we;
    logic  rf_we;
    logic  rf_dst_rd;
    logic  rf_from_mem;
  } ctrl_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    y    = sub ? (a - b) : (a + b);
    zero = (y == '0);
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [W-1:0]            wdata,
  input  logic [$clog2(NREG)-1:0] raddr1,
  input  logic [$clog2(NREG)-1:0] raddr2,
  output logic [W-1:0]            rdata1,
  output logic [W-1:0]            rdata2
);
  localparam int AW = $clog2(NREG);

  logic [W-1:0] regs [NREG];

  // R8 register 0 is never written
  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  always_comb begin
    rdata1 = (raddr1 == AW'(0)) ? '0 : regs[raddr1];
    rdata2 = (raddr2 == AW'(0)) ? '0 : regs[raddr2];
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  output state_t      state,
  output ctrl_t       ctl
);
  state_t nxt;
  logic   is_arith;

  assign is_arith = (opcode == OP_RT) && (funct == FN_ADD || funct == FN_SUB);

  always_comb begin
    nxt = S_IF;
    unique case (state)
      S_IF: nxt = S_IW;
      S_IW: nxt = S_ID;
      S_ID: begin
        if (opcode == OP_LW || opcode == OP_SW) nxt = S_EA;
        else if (opcode == OP_BEQ)              nxt = S_BR;
        else if (is_arith)                      nxt = S_EX;
        else                                    nxt = S_IF; // R9 unknown: back to fetch
      end
      S_EA: nxt = (opcode == OP_LW) ? S_MR : S_MS;
      S_MR: nxt = S_WB;
      S_EX: nxt = S_RW;
      default: nxt = S_IF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IF;
    else     state <= nxt;
  end

  always_comb begin
    ctl = '0;
    unique case (state)
      S_IF: begin
        ctl.mem_re   = 1'b1;
        ctl.b_sel    = BSEL_FOUR;
        ctl.pc_write = 1'b1;
      end
      S_IW: ctl.ir_write = 1'b1;
      S_ID: begin
        ctl.ab_write     = 1'b1;
        ctl.b_sel        = BSEL_BOFF;
        ctl.target_write = 1'b1;
      end
      S_EA: begin
        ctl.a_sel        = 1'b1;
        ctl.b_sel        = BSEL_IMM;
        ctl.aluout_write = 1'b1;
      end
      S_MR: begin
        ctl.iord   = 1'b1;
        ctl.mem_re = 1'b1;
      end
      S_WB: begin
        ctl.rf_we       = 1'b1;
        ctl.rf_from_mem = 1'b1;
      end
      S_MS: begin
        ctl.iord   = 1'b1;
        ctl.mem_we = 1'b1;
      end
      S_EX: begin
        ctl.a_sel        = 1'b1;
        ctl.b_sel        = BSEL_REG;
        ctl.alu_sub      = (funct == FN_SUB);
        ctl.aluout_write = 1'b1;
      end
      S_RW: begin
        ctl.rf_we     = 1'b1;
        ctl.rf_dst_rd = 1'b1;
      end
      S_BR: begin
        ctl.a_sel         = 1'b1;
        ctl.b_sel         = BSEL_REG;
        ctl.alu_sub       = 1'b1;
        ctl.pc_write_cond = 1'b1;
        ctl.pc_src        = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int          W        = 32,
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] mem_addr,
  output logic         mem_re,
  output logic         mem_we,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata
);
  localparam int AW = $clog2(NREG);

  logic [W-1:0] pc_q, ir_q, a_q, b_q, tgt_q, aluout_q;
  state_t       state;
  ctrl_t        ctl;

  logic [5:0]   opcode, funct;
  logic [W-1:0] sx_imm, alu_a, alu_b, alu_y;
  logic         alu_zero, pc_en;
  logic [W-1:0] rf_rd1, rf_rd2, rf_wdata;
  logic [AW-1:0] rf_waddr;

  // R4 field positions
  assign opcode = ir_q[31:26];
  assign funct  = ir_q[5:0];
  assign sx_imm = {{(W-16){ir_q[15]}}, ir_q[15:0]};

  mc_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .funct  (funct),
    .state  (state),
    .ctl    (ctl)
  );

  always_comb begin
    alu_a = ctl.a_sel ? a_q : pc_q;
    unique case (ctl.b_sel)
      BSEL_REG:  alu_b = b_q;
      BSEL_FOUR: alu_b = W'(4);
      BSEL_IMM:  alu_b = sx_imm;
      default:   alu_b = sx_imm << 2;
    endcase
  end

  mc_alu #(.W(W)) u_alu (
    .a    (alu_a),
    .b    (alu_b),
    .sub  (ctl.alu_sub),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign rf_waddr = ctl.rf_dst_rd ? ir_q[11 +: AW] : ir_q[16 +: AW];
  assign rf_wdata = ctl.rf_from_mem ? mem_rdata : aluout_q;

  mc_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk    (clk),
    .we     (ctl.rf_we),
    .waddr  (rf_waddr),
    .wdata  (rf_wdata),
    .raddr1 (ir_q[21 +: AW]),
    .raddr2 (ir_q[16 +: AW]),
    .rdata1 (rf_rd1),
    .rdata2 (rf_rd2)
  );

  assign pc_en = ctl.pc_write | (ctl.pc_write_cond & alu_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= W'(RESET_PC);
      ir_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      tgt_q    <= '0;
      aluout_q <= '0;
    end else begin
      if (pc_en)            pc_q     <= ctl.pc_src ? tgt_q : alu_y;
      if (ctl.ir_write)     ir_q     <= mem_rdata;
      if (ctl.ab_write)     begin a_q <= rf_rd1; b_q <= rf_rd2; end
      if (ctl.target_write) tgt_q    <= alu_y;
      if (ctl.aluout_write) aluout_q <= alu_y;
    end
  end

  assign mem_addr  = ctl.iord ? aluout_q : pc_q;
  assign mem_re    = ctl.mem_re;
  assign mem_we    = ctl.mem_we;
  assign mem_wdata = b_q;

  // R10
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  // R10
  we_last_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (mem_re && mem_addr == pc_q));

  // R7
  br_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_BR && a_q == b_q) |=> (pc_q == $past(tgt_q)));

  // R7
  br_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_BR && a_q != b_q) |=> $stable(pc_q));

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != S_IF && state != S_BR) |=> $stable(pc_q));

  // R3
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != S_IW) |=> $stable(ir_q));

endmodule

// File: tb/tb_mc_core.sv
`timescale 1ns/1ps
module tb_mc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_re, mem_we;

  always #4 clk = ~clk;

  mc_core dut (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  logic [31:0] mem  [256];
  logic [31:0] refm [256];
  logic [31:0] refr [32];
  int errors = 0;
  int checks = 0;

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[9:2]];
  end

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc, len, kind;
    logic [31:0] pc, npc, ea, wd, ins, sx;
    logic [5:0] op;
    int rs, rt, rd;

    for (int i = 0; i < 256; i++) begin mem[i] = '0; end
    for (int i = 0; i < 32; i++) begin refr[i] = '0; end
    // R4 encodings used below
    mem[0]  = enc_i(6'h23, 0, 1, 'h200);
    mem[1]  = enc_i(6'h23, 0, 2, 'h204);
    mem[2]  = enc_r(1, 2, 3, 6'h20);
    mem[3]  = enc_r(1, 2, 4, 6'h22);
    mem[4]  = enc_i(6'h2B, 0, 3, 'h208);
    mem[5]  = enc_i(6'h2B, 0, 4, 'h20C);
    mem[6]  = enc_i(6'h04, 1, 2, 1);
    mem[7]  = enc_r(3, 3, 5, 6'h20);
    mem[8]  = enc_i(6'h04, 1, 1, 1);
    mem[9]  = enc_i(6'h2B, 0, 1, 'h210);
    mem[10] = enc_i(6'h23, 0, 9, 'h218);
    mem[11] = enc_i(6'h2B, 9, 5, -8);
    mem[12] = enc_r(1, 2, 0, 6'h20);
    mem[13] = enc_i(6'h2B, 0, 0, 'h22C);
    mem[14] = 32'hFC00_0000;
    mem[15] = enc_i(6'h2B, 0, 2, 'h224);
    mem[16] = enc_i(6'h04, 0, 0, -1);
    mem['h200 >> 2] = 32'd5;
    mem['h204 >> 2] = 32'd7;
    mem['h218 >> 2] = 32'h230;
    for (int i = 0; i < 256; i++) begin refm[i] = mem[i]; end

    repeat (3) @(negedge clk);
    chk("R1 reset re", {31'd0, mem_re}, 32'd1);
    chk("R1 reset we", {31'd0, mem_we}, 32'd0);
    chk("R1 reset addr", mem_addr, 32'h0);
    rst = 1'b0;

    pc = 32'h0; cyc = 0; len = 3; kind = 0; npc = 0; ea = 0; wd = 0;
    for (int t = 0; t < 400; t++) begin
      if (cyc == 0) begin
        ins = refm[pc[9:2]];
        op = ins[31:26]; rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        sx = {{16{ins[15]}}, ins[15:0]};
        npc = pc + 4; len = 3; kind = 0;
        ea = refr[rs] + sx;
        if (op == 6'h23) begin
          len = 6; kind = 1;
          if (rt != 0) refr[rt] = refm[ea[9:2]];
        end else if (op == 6'h2B) begin
          len = 5; kind = 2; wd = refr[rt]; refm[ea[9:2]] = wd;
        end else if (op == 6'h04) begin
          len = 4;
          if (refr[rs] == refr[rt]) npc = pc + 4 + (sx << 2);
        end else if (op == 6'h00 && (ins[5:0] == 6'h20 || ins[5:0] == 6'h22)) begin
          len = 5;
          if (rd != 0) refr[rd] = (ins[5:0] == 6'h20) ? refr[rs] + refr[rt] : refr[rs] - refr[rt];
        end
      end
      if (cyc == 0) begin
        chk("R2 fetch re/we", {30'd0, mem_re, mem_we}, 32'd2);
        chk("R2 fetch addr", mem_addr, pc);
      end else if (cyc == 4 && kind == 1) begin
        chk("R5 load re/we", {30'd0, mem_re, mem_we}, 32'd2);
        chk("R5 load addr", mem_addr, ea);
      end else if (cyc == 4 && kind == 2) begin
        chk("R10 store re/we", {30'd0, mem_re, mem_we}, 32'd1);
        chk("R5 store addr", mem_addr, ea);
        chk("R5 store data", mem_wdata, wd);
      end else begin
        chk("R3 idle re/we", {30'd0, mem_re, mem_we}, 32'd0);
      end
      cyc++;
      if (cyc == len) begin cyc = 0; pc = npc; end
      @(negedge clk);
    end

    chk("R6 add result", mem['h208 >> 2], 32'd12);
    chk("R6 sub wrap", mem['h20C >> 2], 32'hFFFF_FFFE);
    chk("R7 skipped store", mem['h210 >> 2], 32'd0);
    chk("R5 negative offset store", mem['h228 >> 2], 32'd24);
    chk("R8 zero register", mem['h22C >> 2], 32'd0);
    chk("R9 after unknown op", mem['h224 >> 2], 32'd7);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule